// File: doc/BRIEF.md
# Floating-Point Sign, Compare and Classify Unit

This unit executes the floating-point operations that need no arithmetic datapath: sign injection, minimum, maximum, the three ordered compares and classification. Operands come from a 64-bit register file and each operation selects single or double precision on its own. Single values sit in the lower half of a register, and the upper half must be all ones to count as valid.

Sign-injection, minimum and maximum results go back to a floating-point register. Compare and classify results are integer values. A one-bit flag on the result says which kind of register file the result is for. An invalid-operation flag is raised for the NaN cases listed below. Every operation takes exactly one cycle, and all outputs are registered.

Top module: `fpscc_top`

## Requirements
- R1: A result appears with out_valid high on the clock edge after the one that samples in_valid high, and out_valid is low after any edge that sampled in_valid low. Synchronous reset clears out_valid, out_result, out_invalid and out_fp_wr to 0.
- R2: The op codes are 0 (take the sign of b), 1 (take the inverse of b's sign) and 2 (sign of a XOR sign of b). These ops change only the sign bit of a: bit 63 in double, bit 31 in single. The remaining bits of a are returned unchanged, out_invalid is 0 and out_fp_wr is 1.
- R3: in_dbl=1 selects double precision over all 64 bits. With in_dbl=0 the operand is the low 32 bits. An operand whose bits 63..32 are not all ones is treated as the single value 0x7FC00000.
- R4: The compare codes are 5 (equal), 6 (less than) and 7 (less or equal). The Boolean answer is in bit 0, bits 63..1 are 0, and out_fp_wr is 0. Negative zero equals positive zero, and a compare with a NaN operand yields 0.
- R5: Less-than and less-or-equal raise out_invalid when either operand is any NaN. Equal raises it only for a signaling NaN, which has an all-ones exponent, a nonzero fraction and a clear top fraction bit.
- R6: Code 3 is minimum and code 4 is maximum. Each returns one of the operands, with negative zero ordered below positive zero. If only one operand is NaN, the other operand is returned. If both are NaN, the result is the canonical quiet NaN: 0x7FF8000000000000 in double, 0x7FC00000 in single. out_invalid is raised when either operand is a signaling NaN. out_fp_wr is 1.
- R7: Code 8 classifies a into a one-hot mask in bits 9..0, with bits 63..10 at 0 and out_fp_wr at 0. The bits are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN.
- R8: Every single-precision result written to a floating-point register has bits 63..32 set to all ones.
- R9: Codes 9 to 15 produce out_result 0, out_invalid 0 and out_fp_wr 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 4 | Operation code |
| in_dbl | input | 1 | 1 = double precision, 0 = single |
| in_a | input | 64 | First operand register |
| in_b | input | 64 | Second operand register |
| out_valid | output | 1 | Result registered this cycle |
| out_fp_wr | output | 1 | 1 = result for FP register, 0 = for integer register |
| out_result | output | 64 | Result value |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
On every cycle, the assertions check the one-cycle valid timing and the reset state. They also check that a class result is one-hot and that a compare result is a single bit going to the integer file. The other cycle checks cover the sign-injection magnitude, that a double minimum or maximum returns an operand or the canonical NaN, and single-precision boxing. Only the directed scenarios can show the values themselves. These are the ordering of the two zeros, which operand minimum and maximum choose, the NaN rules for the invalid flag, the treatment of improperly boxed inputs, and the class bit for each category.

// File: rtl/fpscc_pkg.sv
package fpscc_pkg;
  localparam int XLEN    = 64;
  localparam int SW      = 32;
  localparam int DEXP    = 11;
  localparam int DMAN    = 52;
  localparam int SEXP    = 8;
  localparam int SMAN    = 23;
  localparam int CLASS_W = 10;
  localparam int OP_W    = 4;

  localparam logic [SW-1:0]   CNAN_S = 32'h7FC0_0000;
  localparam logic [XLEN-1:0] CNAN_D = 64'h7FF8_0000_0000_0000;

  typedef enum logic [OP_W-1:0] {
    OP_SGNJ  = 4'd0,
    OP_SGNJN = 4'd1,
    OP_SGNJX = 4'd2,
    OP_MIN   = 4'd3,
    OP_MAX   = 4'd4,
    OP_EQ    = 4'd5,
    OP_LT    = 4'd6,
    OP_LE    = 4'd7,
    OP_CLASS = 4'd8
  } op_e;

  typedef struct packed {
    logic            sign;
    logic            zero;
    logic            nan;
    logic            snan;
    logic [XLEN-2:0] mag;
    logic [XLEN-1:0] val;
  } opnd_t;
endpackage

// File: rtl/fpscc_unpack.sv
module fpscc_unpack
  import fpscc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int SWD = SW
) (
  input  logic         dbl,
  input  logic [W-1:0] raw,
  output opnd_t        o
);
  localparam int MAG_PAD = W - SWD;

  logic           boxed;
  logic [SWD-1:0] sword;
  logic           exp_ones, exp_zero, man_zero, man_msb;

  always_comb begin
    boxed = &raw[W-1:SWD];
    sword = boxed ? raw[SWD-1:0] : CNAN_S;
    if (dbl) begin
      o.sign   = raw[W-1];
      exp_ones = &raw[W-2:DMAN];
      exp_zero = ~|raw[W-2:DMAN];
      man_zero = ~|raw[DMAN-1:0];
      man_msb  = raw[DMAN-1];
      o.mag    = raw[W-2:0];
      o.val    = raw;
    end else begin
      o.sign   = sword[SWD-1];
      exp_ones = &sword[SWD-2:SMAN];
      exp_zero = ~|sword[SWD-2:SMAN];
      man_zero = ~|sword[SMAN-1:0];
      man_msb  = sword[SMAN-1];
      o.mag    = {{MAG_PAD{1'b0}}, sword[SWD-2:0]};
      o.val    = {{(W-SWD){1'b1}}, sword};
    end
    o.zero = exp_zero & man_zero;
    o.nan  = exp_ones & ~man_zero;
    o.snan = exp_ones & ~man_zero & ~man_msb;
  end
endmodule

// File: rtl/fpscc_sign.sv
module fpscc_sign
  import fpscc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int SWD = SW
) (
  input  logic [OP_W-1:0] op,
  input  logic            dbl,
  input  opnd_t           a,
  input  logic            b_sign,
  output logic [W-1:0]    res
);
  logic ns;

  always_comb begin
    case (op)
      OP_SGNJN: ns = ~b_sign;
      OP_SGNJX: ns = a.sign ^ b_sign;
      default:  ns = b_sign;
    endcase
    if (dbl) res = {ns, a.val[W-2:0]};
    else     res = {{(W-SWD){1'b1}}, ns, a.val[SWD-2:0]};
  end
endmodule

// File: rtl/fpscc_cmp.sv
module fpscc_cmp
  import fpscc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int SWD = SW
) (
  input  logic         dbl,
  input  logic         want_max,
  input  opnd_t        a,
  input  opnd_t        b,
  output logic         feq,
  output logic         flt,
  output logic         any_nan,
  output logic         any_snan,
  output logic [W-1:0] mm_res
);
  logic both_zero, lt_tot, same_bits;
  logic [W-1:0] cnan;

  always_comb begin
    any_nan   = a.nan | b.nan;
    any_snan  = a.snan | b.snan;
    both_zero = a.zero & b.zero;
    same_bits = (a.val == b.val);
    if (a.sign != b.sign)  lt_tot = a.sign;
    else if (!a.sign)      lt_tot = (a.mag < b.mag);
    else                   lt_tot = (b.mag < a.mag);

    feq = ~any_nan & (same_bits | both_zero);
    flt = ~any_nan & ~both_zero & lt_tot;

    cnan = dbl ? CNAN_D : {{(W-SWD){1'b1}}, CNAN_S};
    if (a.nan && b.nan)    mm_res = cnan;
    else if (a.nan)        mm_res = b.val;
    else if (b.nan)        mm_res = a.val;
    else if (want_max)     mm_res = lt_tot ? b.val : a.val;
    else                   mm_res = (lt_tot | same_bits) ? a.val : b.val;
  end
endmodule

// File: rtl/fpscc_class.sv
module fpscc_class
  import fpscc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CLASS_W
) (
  input  logic          dbl,
  input  logic [W-1:0]  val,
  output logic [CW-1:0] mask
);
  logic s, eo, ez, mz, mmsb;

  always_comb begin
    if (dbl) begin
      s    = val[W-1];
      eo   = &val[W-2:DMAN];
      ez   = ~|val[W-2:DMAN];
      mz   = ~|val[DMAN-1:0];
      mmsb = val[DMAN-1];
    end else begin
      s    = val[SW-1];
      eo   = &val[SW-2:SMAN];
      ez   = ~|val[SW-2:SMAN];
      mz   = ~|val[SMAN-1:0];
      mmsb = val[SMAN-1];
    end
    mask    = '0;
    mask[0] =  s & eo & mz;
    mask[1] =  s & ~eo & ~ez;
    mask[2] =  s & ez & ~mz;
    mask[3] =  s & ez & mz;
    mask[4] = ~s & ez & mz;
    mask[5] = ~s & ez & ~mz;
    mask[6] = ~s & ~eo & ~ez;
    mask[7] = ~s & eo & mz;
    mask[8] = eo & ~mz & ~mmsb;
    mask[9] = eo & ~mz & mmsb;
  end
endmodule

// File: rtl/fpscc_top.sv
module fpscc_top
  import fpscc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int SWD = SW,
  parameter int CW = CLASS_W,
  parameter int OW = OP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [OW-1:0] in_op,
  input  logic          in_dbl,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic          out_valid,
  output logic          out_fp_wr,
  output logic [W-1:0]  out_result,
  output logic          out_invalid
);
  localparam int NOPND = 2;

  logic [W-1:0] raw [NOPND];
  opnd_t        opd [NOPND];

  assign raw[0] = in_a;
  assign raw[1] = in_b;

  for (genvar g = 0; g < NOPND; g++) begin : g_unpack
    fpscc_unpack #(.W(W), .SWD(SWD)) unpack_i (
      .dbl(in_dbl), .raw(raw[g]), .o(opd[g])
    );
  end

  logic [W-1:0]  sgn_res, mm_res;
  logic [CW-1:0] cls_mask;
  logic          feq, flt, any_nan, any_snan;

  fpscc_sign #(.W(W), .SWD(SWD)) sign_i (
    .op(in_op), .dbl(in_dbl), .a(opd[0]), .b_sign(opd[1].sign), .res(sgn_res)
  );

  fpscc_cmp #(.W(W), .SWD(SWD)) cmp_i (
    .dbl(in_dbl), .want_max(in_op == OP_MAX), .a(opd[0]), .b(opd[1]),
    .feq(feq), .flt(flt), .any_nan(any_nan), .any_snan(any_snan), .mm_res(mm_res)
  );

  fpscc_class #(.W(W), .CW(CW)) class_i (
    .dbl(in_dbl), .val(opd[0].val), .mask(cls_mask)
  );

  logic [W-1:0] nx_res;
  logic         nx_fp, nx_inv;

  always_comb begin
    nx_res = '0;
    nx_fp  = 1'b0;
    nx_inv = 1'b0;
    case (in_op)
      OP_SGNJ, OP_SGNJN, OP_SGNJX: begin
        nx_res = sgn_res;
        nx_fp  = 1'b1;
      end
      OP_MIN, OP_MAX: begin
        nx_res = mm_res;
        nx_fp  = 1'b1;
        nx_inv = any_snan;
      end
      OP_EQ: begin
        nx_res[0] = feq;
        nx_inv    = any_snan;
      end
      OP_LT: begin
        nx_res[0] = flt;
        nx_inv    = any_nan;
      end
      OP_LE: begin
        nx_res[0] = flt | feq;
        nx_inv    = any_nan;
      end
      OP_CLASS: nx_res[CW-1:0] = cls_mask;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_fp_wr   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fp_wr   <= nx_fp;
        out_result  <= nx_res;
        out_invalid <= nx_inv;
      end
    end
  end
endmodule

// File: rtl/fpscc_chk.sv
module fpscc_chk
  import fpscc_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [OP_W-1:0] in_op,
  input logic          in_dbl,
  input logic [XLEN-1:0] in_a,
  input logic [XLEN-1:0] in_b,
  input logic          out_valid,
  input logic          out_fp_wr,
  input logic [XLEN-1:0] out_result,
  input logic          out_invalid
);
  logic is_sgn, is_mm, is_cmp;
  assign is_sgn = (in_op == OP_SGNJ) || (in_op == OP_SGNJN) || (in_op == OP_SGNJX);
  assign is_mm  = (in_op == OP_MIN) || (in_op == OP_MAX);
  assign is_cmp = (in_op == OP_EQ) || (in_op == OP_LT) || (in_op == OP_LE);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("valid lost"); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid) else $error("spurious valid"); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_invalid && !out_fp_wr)) else $error("reset state"); // R1
  AST_SGN_MAG_DBL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_sgn && in_dbl) |=> (out_result[XLEN-2:0] == $past(in_a[XLEN-2:0]) && out_fp_wr && !out_invalid))
    else $error("sign op changed magnitude"); // R2
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> (out_result[XLEN-1:1] == '0 && !out_fp_wr)) else $error("compare not boolean"); // R4
  AST_MM_PICK_DBL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_mm && in_dbl) |=> (out_result == $past(in_a) || out_result == $past(in_b) || out_result == CNAN_D))
    else $error("minmax foreign value"); // R6
  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CLASS) |=> ($countones(out_result[CLASS_W-1:0]) == 1 && out_result[XLEN-1:CLASS_W] == '0 && !out_fp_wr))
    else $error("class not one-hot"); // R7
  AST_SGL_BOXED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dbl && (is_sgn || is_mm)) |=> (out_result[XLEN-1:SW] == '1)) else $error("single not boxed"); // R8
  AST_UNDEF_OP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > OP_CLASS) |=> (out_result == '0 && !out_invalid && !out_fp_wr)) else $error("undefined op output"); // R9
endmodule

bind fpscc_top fpscc_chk chk_i (.*);

// File: tb/fpscc_top_tb_top.sv
`timescale 1ns/1ps
module fpscc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic        in_dbl;
  logic [63:0] in_a, in_b;
  logic        out_valid, out_fp_wr, out_invalid;
  logic [63:0] out_result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [63:0] BX   = 64'hFFFF_FFFF_0000_0000;
  localparam logic [63:0] D1   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D2   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D3   = 64'h4008_0000_0000_0000;
  localparam logic [63:0] D5   = 64'h4014_0000_0000_0000;
  localparam logic [63:0] DM1  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] DM2  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SN   = 64'h7FF0_0000_0000_0001;

  always #5 clk = ~clk;

  fpscc_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dbl(in_dbl),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_fp_wr(out_fp_wr),
    .out_result(out_result), .out_invalid(out_invalid)
  );

  task automatic run(input logic [3:0] op, input logic dbl, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_dbl = dbl; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [63:0] er, input logic ei, input logic ef);
    n_tests++;
    if (out_valid !== 1'b1 || out_result !== er || out_invalid !== ei || out_fp_wr !== ef) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b res=%h inv=%0b fp=%0b expected v=1 res=%h inv=%0b fp=%0b",
               tag, out_valid, out_result, out_invalid, out_fp_wr, er, ei, ef);
    end
  endtask

  task automatic op_chk(input string tag, input logic [3:0] op, input logic dbl,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] er, input logic ei, input logic ef);
    run(op, dbl, a, b);
    check(tag, er, ei, ef);
  endtask

  task automatic t_reset;
    n_tests++;
    if (out_valid !== 1'b0 || out_result !== 64'h0 || out_invalid !== 1'b0 || out_fp_wr !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual v=%0b res=%h inv=%0b fp=%0b expected all 0",
               out_valid, out_result, out_invalid, out_fp_wr);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: actual v=%0b expected v=0", out_valid);
    end
  endtask

  task automatic t_sign_dbl;
    op_chk("R2 sgnj dbl",  4'd0, 1'b1, D3, DM1, 64'hC008_0000_0000_0000, 1'b0, 1'b1);
    op_chk("R2 sgnjn dbl", 4'd1, 1'b1, D3, DM1, D3, 1'b0, 1'b1);
    op_chk("R2 sgnjx dbl", 4'd2, 1'b1, DM1, DM1, D1, 1'b0, 1'b1);
  endtask

  task automatic t_sign_sgl;
    op_chk("R2 R8 sgnjn sgl", 4'd1, 1'b0, BX | 64'h4040_0000, BX | 64'hBF80_0000,
           BX | 64'h4040_0000, 1'b0, 1'b1);
    op_chk("R2 R8 sgnjx sgl", 4'd2, 1'b0, BX | 64'hC040_0000, BX | 64'h3F80_0000,
           BX | 64'hC040_0000, 1'b0, 1'b1);
  endtask

  task automatic t_unboxed;
    op_chk("R3 unboxed sgnj", 4'd0, 1'b0, 64'h0000_0000_4040_0000, BX | 64'h3F80_0000,
           BX | 64'h7FC0_0000, 1'b0, 1'b1);
    op_chk("R3 unboxed class", 4'd8, 1'b0, 64'h1234_0000_0000_0000, 64'h0,
           64'h200, 1'b0, 1'b0);
    op_chk("R3 R6 unboxed min", 4'd3, 1'b0, 64'h0000_0000_3F80_0000, BX | 64'h4000_0000,
           BX | 64'h4000_0000, 1'b0, 1'b1);
  endtask

  task automatic t_compare;
    op_chk("R4 eq zeros",  4'd5, 1'b1, NZ, PZ, 64'd1, 1'b0, 1'b0);
    op_chk("R4 lt pos",    4'd6, 1'b1, D1, D2, 64'd1, 1'b0, 1'b0);
    op_chk("R4 lt neg",    4'd6, 1'b1, DM2, DM1, 64'd1, 1'b0, 1'b0);
    op_chk("R4 lt equal",  4'd6, 1'b1, D2, D2, 64'd0, 1'b0, 1'b0);
    op_chk("R4 le equal",  4'd7, 1'b1, D2, D2, 64'd1, 1'b0, 1'b0);
    op_chk("R4 lt zeros",  4'd6, 1'b1, NZ, PZ, 64'd0, 1'b0, 1'b0);
    op_chk("R4 lt sgl",    4'd6, 1'b0, BX | 64'hBF80_0000, BX | 64'h3F80_0000, 64'd1, 1'b0, 1'b0);
  endtask

  task automatic t_cmp_nan;
    op_chk("R5 lt qnan",  4'd6, 1'b1, QN, D1, 64'd0, 1'b1, 1'b0);
    op_chk("R5 le qnan",  4'd7, 1'b1, D1, QN, 64'd0, 1'b1, 1'b0);
    op_chk("R5 eq qnan",  4'd5, 1'b1, QN, QN, 64'd0, 1'b0, 1'b0);
    op_chk("R5 eq snan",  4'd5, 1'b1, D1, SN, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_minmax;
    op_chk("R6 min zeros", 4'd3, 1'b1, PZ, NZ, NZ, 1'b0, 1'b1);
    op_chk("R6 max zeros", 4'd4, 1'b1, NZ, PZ, PZ, 1'b0, 1'b1);
    op_chk("R6 min num",   4'd3, 1'b1, D5, DM2, DM2, 1'b0, 1'b1);
    op_chk("R6 max num",   4'd4, 1'b1, D1, D5, D5, 1'b0, 1'b1);
    op_chk("R6 min qnan",  4'd3, 1'b1, QN, D5, D5, 1'b0, 1'b1);
    op_chk("R6 max 2nan",  4'd4, 1'b1, QN, SN, QN, 1'b1, 1'b1);
    op_chk("R6 min snan",  4'd3, 1'b1, D1, SN, D1, 1'b1, 1'b1);
    op_chk("R6 R8 max sgl 2nan", 4'd4, 1'b0, BX | 64'h7FC0_0001, BX | 64'hFFC0_0000,
           BX | 64'h7FC0_0000, 1'b0, 1'b1);
  endtask

  task automatic t_class;
    op_chk("R7 -inf",  4'd8, 1'b1, 64'hFFF0_0000_0000_0000, 64'h0, 64'h001, 1'b0, 1'b0);
    op_chk("R7 -norm", 4'd8, 1'b1, DM1, 64'h0, 64'h002, 1'b0, 1'b0);
    op_chk("R7 -sub",  4'd8, 1'b1, 64'h8000_0000_0000_0001, 64'h0, 64'h004, 1'b0, 1'b0);
    op_chk("R7 -zero", 4'd8, 1'b1, NZ, 64'h0, 64'h008, 1'b0, 1'b0);
    op_chk("R7 +zero", 4'd8, 1'b1, PZ, 64'h0, 64'h010, 1'b0, 1'b0);
    op_chk("R7 +sub",  4'd8, 1'b1, 64'h1, 64'h0, 64'h020, 1'b0, 1'b0);
    op_chk("R7 +norm", 4'd8, 1'b1, D1, 64'h0, 64'h040, 1'b0, 1'b0);
    op_chk("R7 +inf",  4'd8, 1'b1, 64'h7FF0_0000_0000_0000, 64'h0, 64'h080, 1'b0, 1'b0);
    op_chk("R7 snan",  4'd8, 1'b1, SN, 64'h0, 64'h100, 1'b0, 1'b0);
    op_chk("R7 qnan",  4'd8, 1'b1, QN, 64'h0, 64'h200, 1'b0, 1'b0);
    op_chk("R7 sgl +inf", 4'd8, 1'b0, BX | 64'h7F80_0000, 64'h0, 64'h080, 1'b0, 1'b0);
  endtask

  task automatic t_undef;
    op_chk("R9 op 12", 4'd12, 1'b1, SN, QN, 64'h0, 1'b0, 1'b0);
    op_chk("R9 op 15", 4'd15, 1'b0, BX | 64'h3F80_0000, BX, 64'h0, 1'b0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_dbl = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_sign_dbl;
    t_idle;
    t_sign_sgl;
    t_unboxed;
    t_compare;
    t_cmp_nan;
    t_minmax;
    t_class;
    t_undef;
    t_idle;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule